// File: doc/BRIEF.md
# SDRAM Initialization and Command Scheduler

This block drives the command, bank and address pins for a memory built from several ranks of four-bank SDRAM that share one command bus, each rank with its own chip select. After reset it runs the fixed power-up sequence. First it waits a long quiet period. Then it issues a precharge to every bank of every rank, a programmable number of auto refresh commands, and finally a mode register load. After that it serves requests.

Each request is a single read or write. It is carried out as a row activate, then a column command with auto-precharge requested on address bit 10. A free-running interval counter raises a refresh request. Refresh goes to all ranks at once and wins over any user request that is waiting. Every spacing between commands is a parameter in clock cycles. The defaults correspond to a 100 MHz clock at CAS latency 3.

Only one access is in flight at a time. The spacing after a column command is therefore set by the worst of the bank cycle rule, the minimum active time plus precharge, and, for writes, the data-in to activate rule. The data path is outside this block.

Top module: `sdram_cmd_sched`

## Requirements
- R1: While reset is held and for INIT_WAIT clocks after its release, the pins carry NOP. NOP means every sd_cs_n low and RAS, CAS and WE high. The first command is a precharge with sd_addr[10] high and all ranks selected, and it appears exactly INIT_WAIT clocks after reset release.
- R2: The power-up order is: precharge-all, then INIT_REFS refresh commands, then mode register load with sd_addr equal to MODE_WORD, bank 0 and all ranks selected. The first refresh follows the precharge by T_RP clocks. init_done rises with the mode load and stays high.
- R3: The first command after the mode load comes no earlier than T_MRD clocks after it. It comes exactly then when a request is waiting.
- R4: {RAS,CAS,WE} encodings are: NOP 111, activate 011, read 101, write 100, precharge 010, refresh 001, mode load 000. sd_cs_n[r] low selects rank r. Precharge, refresh and mode load select all ranks.
- R5: An access first issues an activate with the row on sd_addr and the bank on sd_ba. Only the requested rank's sd_cs_n is low. T_RCD clocks later it issues a read (req_write=0) or write (req_write=1) to the same rank and bank, with sd_addr[10]=1, the column on sd_addr[8:0] and all other address bits 0.
- R6: After a read, the next command follows after G = max(T_RC−T_RCD, T_RAS−T_RCD+T_RP, T_RRD−T_RCD) clocks. After a write it follows after max(G, T_DAL, T_DPL+T_RP) clocks. It comes exactly then when work is waiting; the default is 6 for both.
- R7: req_ack is high for exactly the cycle in which the activate for the accepted request is on the pins. No activate, read or write appears before init_done.
- R8: After init_done, a refresh becomes due every REF_INTERVAL clocks. With no user traffic, consecutive refreshes are exactly REF_INTERVAL clocks apart.
- R9: When a refresh is due and a user request is waiting at the same decision point, the refresh is issued first.
- R10: After any refresh, the next command comes no earlier than T_RC clocks later. It comes exactly then when work is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is waiting; hold until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rank | input | RW (1) | Target rank |
| req_bank | input | BANK_BITS (2) | Target bank |
| req_row | input | ROW_BITS (12) | Row address |
| req_col | input | COL_BITS (9) | Column address |
| req_ack | output | 1 | Request accepted, coincident with its activate |
| init_done | output | 1 | Power-up sequence complete |
| sd_cs_n | output | RANKS (2) | Per-rank chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BANK_BITS (2) | Bank address |
| sd_addr | output | ROW_BITS (12) | Multiplexed row/column address |

## Verification
All outputs are registered. A command decided at clock edge k is therefore visible from edge k onward. The spacing between two commands equals the loaded wait plus one. The bench counts edges since reset release, samples the pins on the falling edge, and compares each command's distance from the previous one with the minimum the requirements give for the previous kind. That distance must be exact while a request is held waiting and at least the minimum once traffic stops. Fields of each activate and column command are compared with the request that was acknowledged at the same edge. The refresh interval is measured between two refreshes issued with no traffic.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  // {RAS, CAS, WE} line levels for each command kind
  function automatic logic [2:0] cmd_rcw(input cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      CMD_MRS: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic bit is_user_cmd(input cmd_e c);
    return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // clocks from a column command (auto-precharge) to the next command
  function automatic int unsigned access_gap(input int unsigned rc, input int unsigned rcd,
                                             input int unsigned ras, input int unsigned rp,
                                             input int unsigned rrd, input int unsigned dpl,
                                             input int unsigned dal, input bit wr);
    int unsigned g;
    g = max2(rc - rcd, ras - rcd + rp);
    g = max2(g, (rrd > rcd) ? rrd - rcd : 1);
    if (wr) g = max2(g, max2(dal, dpl + rp));
    return g;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic grant,
  output logic pend
);
  localparam int unsigned CW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= CW'(INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      if (run) cnt <= tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
      if (tick)       pend <= 1'b1;
      else if (grant) pend <= 1'b0;
    end
  end

  assert_pend_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pend);
  assert_grant_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !tick) |=> !pend);
  assert_grant_only_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_sched_pkg::*;
#(
  parameter int unsigned RANKS     = 2,
  parameter int unsigned ROW_BITS  = 12,
  parameter int unsigned COL_BITS  = 9,
  parameter int unsigned BANK_BITS = 2,
  parameter int unsigned INIT_WAIT = 10000,
  parameter int unsigned INIT_REFS = 2,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_DPL     = 1,
  parameter int unsigned T_DAL     = 4,
  parameter int unsigned T_MRD     = 2,
  parameter logic [ROW_BITS-1:0] MODE_WORD = 12'h030,
  localparam int unsigned RW = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [RW-1:0]        req_rank,
  input  logic [BANK_BITS-1:0] req_bank,
  input  logic [ROW_BITS-1:0]  req_row,
  input  logic [COL_BITS-1:0]  req_col,
  input  logic                 ref_pend,
  output logic                 ref_grant,
  output logic                 ack_q,
  output logic                 init_done_q,
  output cmd_e                 cmd_q,
  output logic [RANKS-1:0]     sel_q,
  output logic [BANK_BITS-1:0] ba_q,
  output logic [ROW_BITS-1:0]  addr_q
);
  localparam int unsigned AP_BIT = 10;
  localparam int unsigned RD_GAP = access_gap(T_RC, T_RCD, T_RAS, T_RP, T_RRD, T_DPL, T_DAL, 1'b0);
  localparam int unsigned WR_GAP = access_gap(T_RC, T_RCD, T_RAS, T_RP, T_RRD, T_DPL, T_DAL, 1'b1);
  localparam int unsigned GMAX   = max2(max2(INIT_WAIT, max2(T_RC, T_RP)),
                                        max2(max2(RD_GAP, WR_GAP), max2(T_MRD, T_RCD)));
  localparam int unsigned GW     = bits_for(GMAX);
  localparam int unsigned REFW   = bits_for(INIT_REFS);

  typedef enum logic [2:0] {ST_PREA, ST_INIT_REF, ST_MODE, ST_IDLE, ST_COL} st_e;

  st_e                  st;
  logic [GW-1:0]        gap;
  logic [REFW-1:0]      refs_left;
  logic [RW-1:0]        lat_rank;
  logic [BANK_BITS-1:0] lat_bank;
  logic [COL_BITS-1:0]  lat_col;
  logic                 lat_wr;
  logic [RANKS-1:0]     req_mask, lat_mask;
  logic [ROW_BITS-1:0]  col_word, all_bank_word;
  logic                 decide;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank_dec
    assign req_mask[r] = (req_rank == RW'(r));
    assign lat_mask[r] = (lat_rank == RW'(r));
  end

  always_comb begin
    col_word = '0;
    col_word[COL_BITS-1:0] = lat_col;
    col_word[AP_BIT] = 1'b1;
    all_bank_word = '0;
    all_bank_word[AP_BIT] = 1'b1;
  end

  assign decide    = (gap == '0);
  assign ref_grant = decide && (st == ST_IDLE) && ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_PREA;
      gap         <= GW'(INIT_WAIT - 1);
      refs_left   <= REFW'(INIT_REFS);
      cmd_q       <= CMD_NOP;
      sel_q       <= '0;
      ba_q        <= '0;
      addr_q      <= '0;
      ack_q       <= 1'b0;
      init_done_q <= 1'b0;
      lat_rank    <= '0;
      lat_bank    <= '0;
      lat_col     <= '0;
      lat_wr      <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      sel_q  <= '0;
      ba_q   <= '0;
      addr_q <= '0;
      ack_q  <= 1'b0;
      if (!decide) begin
        gap <= gap - 1'b1;
      end else begin
        case (st)
          ST_PREA: begin
            cmd_q  <= CMD_PRE;
            sel_q  <= '1;
            addr_q <= all_bank_word;
            gap    <= GW'(T_RP - 1);
            st     <= ST_INIT_REF;
          end
          ST_INIT_REF: begin
            cmd_q     <= CMD_REF;
            sel_q     <= '1;
            gap       <= GW'(T_RC - 1);
            refs_left <= refs_left - 1'b1;
            if (refs_left <= REFW'(1)) st <= ST_MODE;
          end
          ST_MODE: begin
            cmd_q       <= CMD_MRS;
            sel_q       <= '1;
            addr_q      <= MODE_WORD;
            gap         <= GW'(T_MRD - 1);
            init_done_q <= 1'b1;
            st          <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q <= CMD_REF;
              sel_q <= '1;
              gap   <= GW'(T_RC - 1);
            end else if (req_valid) begin
              cmd_q    <= CMD_ACT;
              sel_q    <= req_mask;
              ba_q     <= req_bank;
              addr_q   <= req_row;
              ack_q    <= 1'b1;
              lat_rank <= req_rank;
              lat_bank <= req_bank;
              lat_col  <= req_col;
              lat_wr   <= req_write;
              gap      <= GW'(T_RCD - 1);
              st       <= ST_COL;
            end
          end
          ST_COL: begin
            cmd_q  <= lat_wr ? CMD_WR : CMD_RD;
            sel_q  <= lat_mask;
            ba_q   <= lat_bank;
            addr_q <= col_word;
            gap    <= lat_wr ? GW'(WR_GAP - 1) : GW'(RD_GAP - 1);
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // spacing observers for the assertions, driven from the issued commands
  logic [7:0] since_row, since_act, since_cmd;
  logic       row_seen;
  cmd_e       last_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_row <= '0;
      since_act <= '0;
      since_cmd <= '0;
      row_seen  <= 1'b0;
      last_cmd  <= CMD_NOP;
    end else begin
      if (cmd_q == CMD_ACT || cmd_q == CMD_REF) since_row <= 8'd1;
      else if (since_row != 8'hFF)              since_row <= since_row + 8'd1;
      if (cmd_q == CMD_ACT)                     since_act <= 8'd1;
      else if (since_act != 8'hFF)              since_act <= since_act + 8'd1;
      if (cmd_q != CMD_NOP) begin
        since_cmd <= 8'd1;
        last_cmd  <= cmd_q;
      end else if (since_cmd != 8'hFF) begin
        since_cmd <= since_cmd + 8'd1;
      end
      if (cmd_q == CMD_ACT || cmd_q == CMD_REF) row_seen <= 1'b1;
    end
  end

  assert_row_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_ACT || cmd_q == CMD_REF) && row_seen) |-> (since_row >= 8'(T_RC)));
  assert_act_to_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act == 8'(T_RCD)));
  assert_autoprecharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> addr_q[AP_BIT]);
  assert_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP && last_cmd == CMD_PRE) |-> (since_cmd >= 8'(T_RP)));
  assert_after_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP && last_cmd == CMD_MRS) |-> (since_cmd >= 8'(T_MRD)));
  assert_init_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_q |-> !is_user_cmd(cmd_q));
  assert_ack_with_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (cmd_q == CMD_ACT));
  assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_q |=> init_done_q);

endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_sched_pkg::*;
#(
  parameter int unsigned RANKS     = 2,
  parameter int unsigned ROW_BITS  = 12,
  parameter int unsigned BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [RANKS-1:0]     sel,
  input  logic [BANK_BITS-1:0] ba_i,
  input  logic [ROW_BITS-1:0]  addr_i,
  output logic [RANKS-1:0]     cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [BANK_BITS-1:0] ba,
  output logic [ROW_BITS-1:0]  addr
);
  for (genvar r = 0; r < RANKS; r++) begin : g_cs
    assign cs_n[r] = (cmd == CMD_NOP) ? 1'b0 : ~sel[r];
  end

  assign {ras_n, cas_n, we_n} = cmd_rcw(cmd);
  assign ba   = ba_i;
  assign addr = addr_i;

  assert_rank_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_user_cmd(cmd) |-> ($countones(cs_n) == RANKS - 1));
  assert_shared_all_ranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE || cmd == CMD_REF || cmd == CMD_MRS) |-> (cs_n == '0));

endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
  import sdram_sched_pkg::*;
#(
  parameter int unsigned RANKS        = 2,
  parameter int unsigned ROW_BITS     = 12,
  parameter int unsigned COL_BITS     = 9,
  parameter int unsigned BANK_BITS    = 2,
  parameter int unsigned INIT_WAIT    = 10000,
  parameter int unsigned INIT_REFS    = 2,
  parameter int unsigned REF_INTERVAL = 1562,
  parameter int unsigned T_RCD        = 3,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RC         = 9,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RRD        = 2,
  parameter int unsigned T_DPL        = 1,
  parameter int unsigned T_DAL        = 4,
  parameter int unsigned T_MRD        = 2,
  parameter logic [ROW_BITS-1:0] MODE_WORD = 12'h030,
  localparam int unsigned RW = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [RW-1:0]        req_rank,
  input  logic [BANK_BITS-1:0] req_bank,
  input  logic [ROW_BITS-1:0]  req_row,
  input  logic [COL_BITS-1:0]  req_col,
  output logic                 req_ack,
  output logic                 init_done,
  output logic [RANKS-1:0]     sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [BANK_BITS-1:0] sd_ba,
  output logic [ROW_BITS-1:0]  sd_addr
);
  logic                 ref_pend, ref_grant;
  cmd_e                 cmd_q;
  logic [RANKS-1:0]     sel_q;
  logic [BANK_BITS-1:0] ba_q;
  logic [ROW_BITS-1:0]  addr_q;

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .grant(ref_grant), .pend(ref_pend)
  );

  sdram_cmd_seq #(
    .RANKS(RANKS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .BANK_BITS(BANK_BITS),
    .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_RAS(T_RAS), .T_RRD(T_RRD), .T_DPL(T_DPL), .T_DAL(T_DAL),
    .T_MRD(T_MRD), .MODE_WORD(MODE_WORD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .ref_pend(ref_pend), .ref_grant(ref_grant), .ack_q(req_ack), .init_done_q(init_done),
    .cmd_q(cmd_q), .sel_q(sel_q), .ba_q(ba_q), .addr_q(addr_q)
  );

  sdram_pin_drive #(.RANKS(RANKS), .ROW_BITS(ROW_BITS), .BANK_BITS(BANK_BITS)) u_pins (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .sel(sel_q), .ba_i(ba_q), .addr_i(addr_q),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba(sd_ba), .addr(sd_addr)
  );

endmodule

// File: tb/sdram_cmd_sched_test.sv
module sdram_cmd_sched_test;
  localparam int IW = 40, RI = 100, NREF = 2;
  localparam int TRCD = 3, TRP = 3, TRC = 9, TRAS = 6, TRRD = 2, TDPL = 1, TDAL = 4, TMRD = 2;
  localparam logic [11:0] MODE = 12'h032;
  localparam int G0 = (TRC - TRCD > TRAS - TRCD + TRP) ? TRC - TRCD : TRAS - TRCD + TRP;
  localparam int POST_RD = (G0 > TRRD - TRCD) ? G0 : TRRD - TRCD;
  localparam int WMIN = (TDAL > TDPL + TRP) ? TDAL : TDPL + TRP;
  localparam int POST_WR = (POST_RD > WMIN) ? POST_RD : WMIN;
  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_REF = 5, K_MRS = 6, K_START = 7;
  localparam int NREQ = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [0:0] req_rank = '0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ack, init_done, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n, sd_ba;
  logic [11:0] sd_addr;

  always #4 clk = ~clk;

  sdram_cmd_sched #(
    .INIT_WAIT(IW), .INIT_REFS(NREF), .REF_INTERVAL(RI), .T_RCD(TRCD), .T_RP(TRP),
    .T_RC(TRC), .T_RAS(TRAS), .T_RRD(TRRD), .T_DPL(TDPL), .T_DAL(TDAL), .T_MRD(TMRD),
    .MODE_WORD(MODE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ack(req_ack), .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0, exact = 1'b1;
  int last_k = K_START, last_cyc = 0, cmd_idx = 0;
  int ref_cnt = 0, ref_prev = 0, ref_last = 0, ref_after_access = 0;
  logic exp_wr = 1'b0;
  logic [0:0] exp_rank = '0;
  logic [1:0] exp_bank = '0;
  logic [11:0] exp_row = '0;
  logic [8:0] exp_col = '0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int decode(input logic r, input logic c, input logic w);
    case ({r, c, w})
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return K_PRE;
      3'b001: return K_REF;
      3'b000: return K_MRS;
      default: return K_NOP;
    endcase
  endfunction

  function automatic int min_gap(input int k);
    case (k)
      K_START: return IW;
      K_PRE:   return TRP;
      K_REF:   return TRC;
      K_MRS:   return TMRD;
      K_ACT:   return TRCD;
      K_RD:    return POST_RD;
      default: return POST_WR;
    endcase
  endfunction

  function automatic string gap_tag(input int k);
    case (k)
      K_START: return "R1";
      K_PRE:   return "R2";
      K_REF:   return "R10";
      K_MRS:   return "R3";
      K_ACT:   return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int init_expect(input int idx);
    if (idx == 0) return K_PRE;
    if (idx <= NREF) return K_REF;
    if (idx == NREF + 1) return K_MRS;
    return K_ACT;
  endfunction

  task automatic set_req(input int i);
    req_rank  = 1'(i >> 3);
    req_bank  = 2'(i >> 1);
    req_write = i[0];
    req_row   = 12'h800 ^ 12'(i * 12'h153);
    req_col   = 9'h1FF - 9'(i * 7);
  endtask

  // command monitor, sampling on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k, gap;
      k = decode(sd_ras_n, sd_cas_n, sd_we_n);
      if (req_ack != (k == K_ACT))
        check(1'b0, "R7", "ack versus activate", req_ack, k == K_ACT);
      if (k == K_NOP) begin
        if (sd_cs_n != 2'b00) check(1'b0, "R4", "NOP chip selects", sd_cs_n, 0);
      end else begin
        gap = cyc - last_cyc;
        if (exact) check(gap == min_gap(last_k), gap_tag(last_k), "command spacing", gap, min_gap(last_k));
        else check(gap >= min_gap(last_k), gap_tag(last_k), "minimum spacing", gap, min_gap(last_k));
        if (cmd_idx <= NREF + 2)
          check(k == init_expect(cmd_idx), "R2", "power-up order", k, init_expect(cmd_idx));
        case (k)
          K_PRE: check(sd_addr[10] && sd_cs_n == 2'b00, "R1", "precharge-all fields",
                       {sd_cs_n, sd_addr}, 12'h400);
          K_REF: begin
            check(sd_cs_n == 2'b00, "R8", "refresh selects all ranks", sd_cs_n, 0);
            if (init_done) begin
              ref_prev = ref_last;
              ref_last = cyc;
              ref_cnt++;
              if (exact && (last_k == K_RD || last_k == K_WR)) ref_after_access++;
            end
          end
          K_MRS: check(sd_addr == MODE && sd_ba == 2'b00 && sd_cs_n == 2'b00 && init_done,
                       "R2", "mode load fields", {init_done, sd_cs_n, sd_ba, sd_addr},
                       {1'b1, 4'b0000, MODE});
          K_ACT: begin
            check(init_done, "R7", "activate after init", init_done, 1);
            check(sd_cs_n == ~(2'b01 << exp_rank), "R5", "activate chip selects",
                  sd_cs_n, ~(2'b01 << exp_rank));
            check(sd_ba == exp_bank && sd_addr == exp_row, "R5", "activate bank/row",
                  {sd_ba, sd_addr}, {exp_bank, exp_row});
          end
          default: begin
            check(k == (exp_wr ? K_WR : K_RD), "R5", "column command kind", k,
                  exp_wr ? K_WR : K_RD);
            check(sd_cs_n == ~(2'b01 << exp_rank) && sd_ba == exp_bank, "R5",
                  "column rank/bank", {sd_cs_n, sd_ba}, {~(2'b01 << exp_rank), exp_bank});
            check(sd_addr == {3'b010, exp_col}, "R5", "column address with auto-precharge",
                  sd_addr, {3'b010, exp_col});
          end
        endcase
        last_k = k;
        last_cyc = cyc;
        cmd_idx++;
      end
    end
  end

  initial begin
    int base;
    set_req(0);
    req_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111 && sd_cs_n == 2'b00, "R1",
          "NOP during reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b00111);
    check(!init_done && !req_ack, "R7", "no ack or init_done in reset", {init_done, req_ack}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NREQ; i++) begin
      do begin
        @(posedge clk);
        #2;
      end while (!req_ack);
      exp_wr = req_write;
      exp_rank = req_rank;
      exp_bank = req_bank;
      exp_row = req_row;
      exp_col = req_col;
      if (i < NREQ - 1) set_req(i + 1);
    end
    req_valid = 1'b0;
    exact = 1'b0;
    check(ref_after_access > 0, "R9", "refresh chosen over waiting request", ref_after_access, 1);
    base = ref_cnt;
    while (ref_cnt < base + 3) @(posedge clk);
    @(negedge clk);
    check(ref_last - ref_prev == RI, "R8", "idle refresh interval", ref_last - ref_prev, RI);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111 && !req_ack, "R4", "idle lines NOP",
          {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule